// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

The engine is the hardware half of a circular receive descriptor ring. The ring lives in a small internal descriptor memory that software reads and writes through a word port. Each descriptor takes eight 32-bit words: word 0 holds the status flags and the byte count, word 1 the buffer address, word 2 the interrupt-enable control, and word 4 an update field. Word 4 is cleared on every write-back. A register port sets the ring start index, the maximum buffer size and the maximum frame length. It also carries a poll-demand strobe, an enable bit and the interrupt status and mask.

Frames arrive as a stream of byte strobes with an end marker. At the first byte the engine claims the current descriptor if it owns it, then counts bytes into it. On close it writes back the count and any error flags, gives the descriptor to software and moves on. A frame longer than one buffer continues in the next descriptor. When the engine meets a descriptor it does not own, it halts and waits for a poll demand. Only the byte counts and the descriptor bookkeeping are modelled; the frame data is not stored.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset the enable bit, interrupt status and mask read 0, the frame-length limit reads 1518, and `irq` is 0. Register offsets are: 0 enable (bit 0), 1 ring start index, 2 buffer size, 3 frame-length limit, 4 poll demand (any write), 5 interrupt status (bit 0, write one to clear), 6 interrupt mask (bit 0).
- R2: The engine uses a descriptor only if bit 31 (empty) of its word 0 is set. On write-back, word 0 gets bit 31 cleared and the descriptor's byte count in bits 15:0. Word 4 is cleared. Words 1 and 2 keep their values.
- R3: Bit 29 of word 0 (wrap) is kept on write-back. After a descriptor with wrap set, the engine moves to the ring start index; otherwise it moves to the next index.
- R4: When a frame begins on a descriptor with bit 31 clear, the whole frame is dropped and nothing is written. Later frames are also dropped, even if software re-arms the descriptor, until a poll demand is written.
- R5: On the closing descriptor of a frame, word 0 bit 27 (last) is set. Bit 18 records a CRC error, bit 17 an overrun and bit 20 a non-octet frame, each taken from the stream flags present with the final byte.
- R6: A frame whose total length exceeds the frame-length limit gets bit 21 set in the closing descriptor.
- R7: When a descriptor fills to the buffer size before the frame ends, it is closed with bit 27 clear and the frame continues in the next descriptor. A frame that ends exactly at the buffer size stays in one descriptor with bit 27 set.
- R8: If a descriptor fills and the next descriptor is not owned, the full descriptor is closed with bit 27 and bit 16 (truncated) set. The rest of the frame is dropped and the engine halts until a poll demand.
- R9: When a frame closes (bit 27 written) and word 2 bit 0 of its descriptor is set, the interrupt status bit is set and stays set until software writes a one to clear it. If word 2 bit 0 is clear, the status bit is not set. If a clear and a frame close fall in the same cycle, the status bit ends up set.
- R10: `irq` is high only when both the status bit and the mask bit are set.
- R11: Clearing the enable bit returns the current index to the ring start and drops any frame in progress without a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data (combinational) |
| dm_we | input | 1 | descriptor memory write strobe |
| dm_addr | input | AW (6) | descriptor memory word address: index times 8 plus word |
| dm_wdata | input | 32 | descriptor memory write data |
| dm_rdata | output | 32 | descriptor memory read data (combinational) |
| rx_valid | input | 1 | one received byte this cycle |
| rx_last | input | 1 | this byte ends the frame |
| rx_crc_bad | input | 1 | frame CRC error, valid with rx_last |
| rx_odd_bits | input | 1 | frame not a whole number of octets, valid with rx_last |
| rx_overrun | input | 1 | receive overrun, valid with rx_last |
| irq | output | 1 | masked frame-done interrupt |

## Verification
Two events can hit the sticky interrupt status bit in the same cycle: a software write-one-to-clear and a frame close that sets the bit. The bench drives the clear on the register port on the same negative edge that presents the final byte of a frame, so both reach the same rising edge. It then expects the status bit to read one. A clear written on its own afterwards must read zero.

// File: rtl/rx_desc_ring.sv
module rx_desc_ring #(
  parameter int NDESC    = 8,
  parameter int LENW     = 16,
  parameter int FMAX_RST = 1518,
  parameter int BMAX_RST = 2047
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [2:0]                    reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic                          dm_we,
  input  logic [$clog2(NDESC)+2:0]      dm_addr,
  input  logic [31:0]                   dm_wdata,
  output logic [31:0]                   dm_rdata,
  input  logic                          rx_valid,
  input  logic                          rx_last,
  input  logic                          rx_crc_bad,
  input  logic                          rx_odd_bits,
  input  logic                          rx_overrun,
  output logic                          irq
);
  localparam int IW = $clog2(NDESC);
  localparam int AW = IW + 3;
  localparam int B_E = 31, B_W = 29, B_L = 27, B_LG = 21, B_NO = 20, B_CR = 18, B_OV = 17, B_TR = 16;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP} st_t;
  st_t st;
  logic en, run, ist, imsk;
  logic [IW-1:0] base, cur;
  logic [LENW-1:0] bmax, fmax, bcnt, fcnt;
  logic [31:0] mem [NDESC*8];
  logic [31:0] wb_word;

  wire [31:0]   w0       = mem[{cur, 3'd0}];
  wire          owned    = w0[B_E];
  wire          cur_wrap = w0[B_W];
  wire [IW-1:0] nxt      = (cur_wrap || cur == IW'(NDESC-1)) ? base : cur + 1'b1;
  wire          nxt_own  = mem[{nxt, 3'd0}][B_E];

  wire start = rx_valid && st == S_IDLE;
  wire take  = rx_valid && en && (st == S_RECV || (start && run && owned));
  wire [LENW-1:0] bcnt_n = (st == S_RECV) ? bcnt + 1'b1 : LENW'(1);
  wire [LENW-1:0] fcnt_n = (st == S_RECV) ? fcnt + 1'b1 : LENW'(1);
  wire close_last = take && rx_last;
  wire close_full = take && !rx_last && bcnt_n >= bmax;
  wire trunc      = close_full && !nxt_own;
  wire wb         = close_last || close_full;
  wire fin        = close_last || trunc;
  wire done_evt   = fin && mem[{cur, 3'd2}][0];
  wire poll       = reg_we && reg_addr == 3'd4;
  wire clr        = reg_we && reg_addr == 3'd5 && reg_wdata[0];

  assign dm_rdata = mem[dm_addr];
  assign irq      = ist && imsk;

  always_comb begin
    wb_word       = '0;
    wb_word[B_W]  = cur_wrap;
    wb_word[B_L]  = fin;
    wb_word[B_LG] = fin && fcnt_n > fmax;
    wb_word[B_NO] = close_last && rx_odd_bits;
    wb_word[B_CR] = close_last && rx_crc_bad;
    wb_word[B_OV] = close_last && rx_overrun;
    wb_word[B_TR] = trunc;
    wb_word[15:0] = 16'(bcnt_n);
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {31'd0, en};
      3'd1:    reg_rdata = 32'(base);
      3'd2:    reg_rdata = 32'(bmax);
      3'd3:    reg_rdata = 32'(fmax);
      3'd5:    reg_rdata = {31'd0, ist};
      3'd6:    reg_rdata = {31'd0, imsk};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (dm_we) mem[dm_addr] <= dm_wdata;
    if (wb) begin
      mem[{cur, 3'd0}] <= wb_word;
      mem[{cur, 3'd4}] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; run <= 1'b0; ist <= 1'b0; imsk <= 1'b0;
      base <= '0; cur <= '0; bcnt <= '0; fcnt <= '0; st <= S_IDLE;
      bmax <= LENW'(BMAX_RST); fmax <= LENW'(FMAX_RST);
    end else begin
      if (reg_we) begin
        case (reg_addr)
          3'd0: en   <= reg_wdata[0];
          3'd1: base <= reg_wdata[IW-1:0];
          3'd2: bmax <= reg_wdata[LENW-1:0];
          3'd3: fmax <= reg_wdata[LENW-1:0];
          3'd6: imsk <= reg_wdata[0];
          default: ;
        endcase
      end
      if (!en) begin
        cur <= base; st <= S_IDLE; bcnt <= '0; fcnt <= '0;
      end else if (take) begin
        bcnt <= bcnt_n; fcnt <= fcnt_n;
        st   <= rx_last ? S_IDLE : S_RECV;
        if (wb) begin
          cur <= nxt; bcnt <= '0;
        end
        if (trunc) begin
          st <= S_DROP; run <= 1'b0;
        end
      end else if (rx_valid) begin
        if (start && !owned) run <= 1'b0;
        st <= rx_last ? S_IDLE : S_DROP;
      end
      if (poll) run <= 1'b1;
      if (clr) ist <= 1'b0;
      if (done_evt) ist <= 1'b1;
    end
  end

  assert_claim_owned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wb |-> owned);
  assert_wrap_to_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb && en && cur_wrap) |=> cur == $past(base));
  assert_wb_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb |-> run);
  assert_sticky_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ist && !clr) |=> ist);
  assert_disable_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> st == S_IDLE);
endmodule

// File: tb/sim_rx_desc_ring.sv
module sim_rx_desc_ring;
  localparam int AW = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0; logic [2:0] reg_addr = '0; logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic dm_we = 1'b0; logic [AW-1:0] dm_addr = '0; logic [31:0] dm_wdata = '0;
  logic [31:0] dm_rdata;
  logic rx_valid = 1'b0, rx_last = 1'b0, rx_crc_bad = 1'b0, rx_odd_bits = 1'b0, rx_overrun = 1'b0;
  logic irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rx_desc_ring u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dm_we(dm_we), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .rx_valid(rx_valid), .rx_last(rx_last),
    .rx_crc_bad(rx_crc_bad), .rx_odd_bits(rx_odd_bits), .rx_overrun(rx_overrun), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wdm(input int idx, input int w, input logic [31:0] d);
    @(negedge clk); dm_we = 1'b1; dm_addr = AW'(idx*8 + w); dm_wdata = d;
    @(negedge clk); dm_we = 1'b0;
  endtask

  task automatic rdm(input int idx, input int w, output logic [31:0] d);
    @(negedge clk); dm_addr = AW'(idx*8 + w); #1 d = dm_rdata;
  endtask

  task automatic arm(input int idx, input bit wrap, input bit ie);
    wdm(idx, 0, 32'h8000_0000 | (wrap ? 32'h2000_0000 : 32'h0));
    wdm(idx, 1, 32'h1000 + idx*32'h800);
    wdm(idx, 2, {31'd0, ie});
    wdm(idx, 4, 32'hBD00_0000 | idx);
  endtask

  task automatic send(input int len, input bit crc, input bit odd, input bit ov,
                      input bit clr_at_end, input bit finish);
    for (int b = 0; b < len; b++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_last = finish && (b == len-1);
      rx_crc_bad = rx_last && crc; rx_odd_bits = rx_last && odd; rx_overrun = rx_last && ov;
      if (rx_last && clr_at_end) begin reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd1; end
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0; rx_crc_bad = 1'b0; rx_odd_bits = 1'b0; rx_overrun = 1'b0;
    reg_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rreg(3'd0, d); chk("R1 enable reset", d, 0);
    rreg(3'd3, d); chk("R1 frame limit reset", d, 1518);
    rreg(3'd5, d); chk("R1 status reset", d, 0);
    rreg(3'd6, d); chk("R1 mask reset", d, 0);
    chk("R1 irq reset", {31'd0, irq}, 0);
  endtask

  task automatic t_basic;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) arm(i, i == 3, 1'b1);
    wreg(3'd2, 256); wreg(3'd1, 0); wreg(3'd0, 1); wreg(3'd4, 1);
    send(60, 0, 0, 0, 0, 1);
    rdm(0, 0, d); chk("R2 word0 after frame", d, 32'h0800_003C);
    rdm(0, 1, d); chk("R2 word1 kept", d, 32'h1000);
    rdm(0, 4, d); chk("R2 word4 cleared", d, 0);
    rreg(3'd5, d); chk("R9 status set", d, 1);
    chk("R10 irq masked", {31'd0, irq}, 0);
    wreg(3'd6, 1); #1 chk("R10 irq unmasked", {31'd0, irq}, 1);
    wreg(3'd5, 1); rreg(3'd5, d); chk("R9 status cleared", d, 0);
    chk("R10 irq after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_errors;
    logic [31:0] d;
    send(64, 1, 1, 1, 0, 1);
    rdm(1, 0, d); chk("R5 error flags", d, 32'h0816_0040);
    wreg(3'd3, 100);
    send(120, 0, 0, 0, 0, 1);
    rdm(2, 0, d); chk("R6 length violation", d, 32'h0820_0078);
    wreg(3'd3, 1518);
  endtask

  task automatic t_span;
    logic [31:0] d;
    arm(0, 0, 1); arm(1, 0, 1);
    wreg(3'd2, 32);
    send(70, 0, 0, 0, 0, 1);
    rdm(3, 0, d); chk("R7 first part, wrap kept R3", d, 32'h2000_0020);
    rdm(0, 0, d); chk("R3 wrapped to start, R7 middle part", d, 32'h0000_0020);
    rdm(1, 0, d); chk("R7 final part", d, 32'h0800_0006);
    wreg(3'd5, 1);
  endtask

  task automatic t_stall;
    logic [31:0] d;
    send(10, 0, 0, 0, 0, 1);
    rdm(2, 0, d); chk("R4 unowned untouched", d, 32'h0820_0078);
    rreg(3'd5, d); chk("R4 no status on drop", d, 0);
    arm(2, 0, 1);
    send(10, 0, 0, 0, 0, 1);
    rdm(2, 0, d); chk("R4 halted without poll", d, 32'h8000_0000);
    wreg(3'd4, 1);
    send(15, 0, 0, 0, 0, 1);
    rdm(2, 0, d); chk("R4 resumed after poll", d, 32'h0800_000F);
  endtask

  task automatic t_exact_trunc;
    logic [31:0] d;
    arm(3, 1, 1); arm(0, 0, 1);
    send(32, 0, 0, 0, 0, 1);
    rdm(3, 0, d); chk("R7 exact fill single descriptor", d, 32'h2800_0020);
    rdm(0, 0, d); chk("R7 next not used", d, 32'h8000_0000);
    send(50, 0, 0, 0, 0, 1);
    rdm(0, 0, d); chk("R8 truncated close", d, 32'h0801_0020);
    rdm(1, 0, d); chk("R8 unowned next untouched", d, 32'h0800_0006);
  endtask

  task automatic t_ie;
    logic [31:0] d;
    wreg(3'd5, 1);
    arm(1, 0, 0); wreg(3'd4, 1);
    send(5, 0, 0, 0, 0, 1);
    rdm(1, 0, d); chk("R2 frame into desc1", d, 32'h0800_0005);
    rreg(3'd5, d); chk("R9 no status without enable bit", d, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    arm(2, 0, 1); arm(3, 1, 1);
    send(5, 0, 0, 0, 0, 1);
    rreg(3'd5, d); chk("R9 status set before race", d, 1);
    send(6, 0, 0, 0, 1, 1);
    rreg(3'd5, d); chk("R9 set wins over clear", d, 1);
    rdm(3, 0, d); chk("R3 wrap descriptor", d, 32'h2800_0006);
    wreg(3'd5, 1); rreg(3'd5, d); chk("R9 lone clear", d, 0);
  endtask

  task automatic t_disable;
    logic [31:0] d;
    arm(0, 0, 1); arm(1, 0, 1);
    send(10, 0, 0, 0, 0, 0);
    wreg(3'd1, 1); wreg(3'd0, 0); wreg(3'd0, 1); wreg(3'd4, 1);
    send(8, 0, 0, 0, 0, 1);
    rdm(0, 0, d); chk("R11 dropped frame not written", d, 32'h8000_0000);
    rdm(1, 0, d); chk("R11 restart at ring start", d, 32'h0800_0008);
  endtask

  initial begin
    #(4*150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_basic;
    t_errors;
    t_span;
    t_stall;
    t_exact_trunc;
    t_ie;
    t_same_cycle;
    t_disable;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule